// File: doc/BRIEF.md
# Dual-Issue Pairing Unit

This block sits at the issue stage of an in-order, statically scheduled integer pipeline with two ALU pipes. Every cycle it looks at the two oldest decoded instructions, called the older and the younger slot, and decides whether both can leave together, only the older one can leave, or nothing leaves. Each slot carries a valid bit, a two-bit class code, two source register numbers, a destination register number with a write-enable, and an opaque tag that travels with the instruction.

Instructions that leave are registered into the issue outputs. The older one always goes to ALU pipe 0 and a paired younger one always goes to ALU pipe 1. The multiplier pipe and the single load/store pipe are not extra slots: they ride beside an ALU pipe. A multiply may only ride beside pipe 0. A memory operation may ride beside either pipe, and a select output names the pipe it rides with. Toward decode the block returns, in the same cycle, how many instructions it has taken (0, 1 or 2). The decode queue then drops that many and shifts, so a held younger instruction becomes the older one on the next cycle. A stall input from downstream freezes issue.

Top module: `dual_issue_pair`

## Requirements
- R1: While rst_n is low at a rising edge, and on the cycle after, iss0_vld, iss1_vld, mul_go, mem_go and mem_on_p1 are all 0.
- R2: Nothing issues when old_vld is 0, even if yng_vld is 1 (take = 0). With old_vld 1 and yng_vld 0, exactly one instruction is taken.
- R3: The take output is combinational in the cycle the slots are presented and encodes 0, 1 or 2 as a plain binary count.
- R4: After a rising edge at which take was 1 or 2, iss0_vld is 1 and iss0_tag is the older slot's tag. After an edge at which take was 2, iss1_vld is 1 and iss1_tag is the younger slot's tag. iss1_vld is never 1 while iss0_vld is 0.
- R5: Class codes are 00 plain ALU, 01 multiply, 10 load/store and 11 treated as plain ALU. An older multiply pairs with a younger non-multiply and sets mul_go on the issue cycle.
- R6: A younger multiply never pairs (take = 1). Once it has been shifted into the older slot, it pairs with a younger ALU instruction.
- R7: A load/store may issue from either slot. mem_go is set, and mem_on_p1 is 0 when the older slot carries it and 1 when the younger slot carries it.
- R8: Two load/store instructions never pair (take = 1), and the older one issues on pipe 0 with mem_on_p1 = 0.
- R9: When old_we is 1 and either younger source equals old_rd, only the older instruction is taken.
- R10: When old_we and yng_we are both 1 and yng_rd equals old_rd, only the older instruction is taken. With old_we 0, equal register numbers cause no hold.
- R11: While stall is 1, take is 0, and after the edge iss0_vld and iss1_vld are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stall | input | 1 | Downstream holds issue |
| old_vld | input | 1 | Older slot holds an instruction |
| old_cls | input | 2 | Older class code |
| old_rs1 | input | REG_W | Older first source register |
| old_rs2 | input | REG_W | Older second source register |
| old_rd | input | REG_W | Older destination register |
| old_we | input | 1 | Older writes old_rd |
| old_tag | input | TAG_W | Older instruction tag |
| yng_vld | input | 1 | Younger slot holds an instruction |
| yng_cls | input | 2 | Younger class code |
| yng_rs1 | input | REG_W | Younger first source register |
| yng_rs2 | input | REG_W | Younger second source register |
| yng_rd | input | REG_W | Younger destination register |
| yng_we | input | 1 | Younger writes yng_rd |
| yng_tag | input | TAG_W | Younger instruction tag |
| take | output | 2 | Instructions consumed this cycle |
| iss0_vld | output | 1 | ALU pipe 0 receives an instruction |
| iss0_tag | output | TAG_W | Tag on ALU pipe 0 |
| iss1_vld | output | 1 | ALU pipe 1 receives an instruction |
| iss1_tag | output | TAG_W | Tag on ALU pipe 1 |
| mul_go | output | 1 | Multiplier pipe rides with pipe 0 |
| mem_go | output | 1 | Load/store pipe is in use |
| mem_on_p1 | output | 1 | Load/store pipe rides with pipe 1 (else pipe 0) |

## Verification
The take count has no register in its path, so the bench drives a slot pair on a falling edge and samples take one nanosecond later, within the same cycle. The pipe valids, tags, mul_go, mem_go and mem_on_p1 pass through one register, so each is sampled at the next falling edge, half a cycle after the rising edge that captured the decision. The new stimulus is applied at that same falling edge, so every result is read exactly one cycle after the pair that caused it. For held instructions the bench acts as the decode queue: it shifts the younger instruction into the older slot before the following pair.

// File: rtl/di_pkg.sv
// Package: shared class codes for the dual-issue pairing unit.
// Assumes the decoder delivers a 2-bit class per instruction.
package di_pkg;
    typedef enum logic [1:0] {
        CLS_ALU = 2'b00,
        CLS_MUL = 2'b01,
        CLS_MEM = 2'b10,
        CLS_RSV = 2'b11
    } ins_cls_e;
endpackage

// File: rtl/di_dep_check.sv
// Module: di_dep_check
// Flags a register dependency of the younger instruction on the older one:
// any younger source, or a written younger destination, that matches a
// written older destination. Purely combinational, NSRC sources per slot.
module di_dep_check #(
    parameter int REG_W = 5,
    parameter int NSRC  = 2
) (
    input  logic                       old_we,
    input  logic [REG_W-1:0]           old_rd,
    input  logic [NSRC-1:0][REG_W-1:0] yng_src,
    input  logic                       yng_we,
    input  logic [REG_W-1:0]           yng_rd,
    output logic                       dep
);
    logic [NSRC-1:0] src_hit;
    logic            dst_hit;

    // one comparator per younger source operand
    generate
        for (genvar s = 0; s < NSRC; s++) begin : g_src
            assign src_hit[s] = (yng_src[s] == old_rd);
        end
    endgenerate

    // output-dependency check: both write the same register
    always_comb begin
        dst_hit = yng_we && (yng_rd == old_rd);
    end

    // combine: only a writing older instruction can create a dependency
    always_comb begin
        dep = old_we && ((|src_hit) || dst_hit);
    end
endmodule

// File: rtl/di_pair_rules.sv
// Module: di_pair_rules
// Applies the slot rules: in-order issue, multiply only beside pipe 0,
// a single load/store pipe, dependency hold and downstream stall.
// Produces the go decisions and the side-pipe attachments.
module di_pair_rules
    import di_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       stall,
    input  logic       old_vld,
    input  logic [1:0] old_cls,
    input  logic       yng_vld,
    input  logic [1:0] yng_cls,
    input  logic       dep,
    output logic       go_old,
    output logic       go_yng,
    output logic       mul_att,
    output logic       mem_att,
    output logic       mem_p1
);
    logic old_mem, yng_mem, yng_mul, slot_clash;

    // class decode of both slots
    always_comb begin
        old_mem = (old_cls == CLS_MEM);
        yng_mem = (yng_cls == CLS_MEM);
        yng_mul = (yng_cls == CLS_MUL);
    end

    // structural clash: younger multiply, or two memory operations
    always_comb begin
        slot_clash = yng_mul || (old_mem && yng_mem);
    end

    // go decisions: older first, younger only when all rules allow
    always_comb begin
        go_old = old_vld && !stall;
        go_yng = go_old && yng_vld && !slot_clash && !dep;
    end

    // side-pipe attachment for whichever slots issue
    always_comb begin
        mul_att = go_old && (old_cls == CLS_MUL);
        mem_att = (go_old && old_mem) || (go_yng && yng_mem);
        mem_p1  = go_yng && yng_mem;
    end

    AST_YNG_NEEDS_OLD: assert property (@(posedge clk) disable iff (!rst_n)
        go_yng |-> (go_old && old_vld)); // R2
    AST_NO_YNG_MUL: assert property (@(posedge clk) disable iff (!rst_n)
        (yng_vld && yng_cls == CLS_MUL) |-> !go_yng); // R6
    AST_ONE_MEM: assert property (@(posedge clk) disable iff (!rst_n)
        (old_cls == CLS_MEM && yng_cls == CLS_MEM) |-> !go_yng); // R8
    AST_STALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stall |-> (!go_old && !go_yng)); // R11
endmodule

// File: rtl/di_issue_reg.sv
// Module: di_issue_reg
// Registers the issue decision into the two ALU pipe slots and the
// side-pipe selects. One cycle from decision to output.
module di_issue_reg #(
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_old,
    input  logic             go_yng,
    input  logic [TAG_W-1:0] old_tag,
    input  logic [TAG_W-1:0] yng_tag,
    input  logic             mul_att,
    input  logic             mem_att,
    input  logic             mem_p1,
    output logic             iss0_vld,
    output logic [TAG_W-1:0] iss0_tag,
    output logic             iss1_vld,
    output logic [TAG_W-1:0] iss1_tag,
    output logic             mul_go,
    output logic             mem_go,
    output logic             mem_on_p1
);
    // valid and select flags, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            iss0_vld  <= 1'b0;
            iss1_vld  <= 1'b0;
            mul_go    <= 1'b0;
            mem_go    <= 1'b0;
            mem_on_p1 <= 1'b0;
        end else begin
            iss0_vld  <= go_old;
            iss1_vld  <= go_yng;
            mul_go    <= mul_att;
            mem_go    <= mem_att;
            mem_on_p1 <= mem_p1;
        end
    end

    // tags load only with an issuing instruction, no reset needed
    always_ff @(posedge clk) begin
        if (go_old) iss0_tag <= old_tag;
        if (go_yng) iss1_tag <= yng_tag;
    end

    AST_P1_BEHIND_P0: assert property (@(posedge clk) disable iff (!rst_n)
        iss1_vld |-> iss0_vld); // R4
    AST_ISSUE_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        go_old |=> iss0_vld); // R4
    AST_SIDE_NEEDS_P0: assert property (@(posedge clk) disable iff (!rst_n)
        (mul_go || mem_go) |-> iss0_vld); // R5
endmodule

// File: rtl/dual_issue_pair.sv
// Module: dual_issue_pair (top)
// Issue-stage pairing unit for a two-ALU in-order pipeline. Assumes the
// decode queue presents its two oldest entries in program order, drops
// 'take' entries each cycle and shifts the rest down.
module dual_issue_pair #(
    parameter int REG_W = 5,
    parameter int TAG_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             stall,
    input  logic             old_vld,
    input  logic [1:0]       old_cls,
    input  logic [REG_W-1:0] old_rs1,
    input  logic [REG_W-1:0] old_rs2,
    input  logic [REG_W-1:0] old_rd,
    input  logic             old_we,
    input  logic [TAG_W-1:0] old_tag,
    input  logic             yng_vld,
    input  logic [1:0]       yng_cls,
    input  logic [REG_W-1:0] yng_rs1,
    input  logic [REG_W-1:0] yng_rs2,
    input  logic [REG_W-1:0] yng_rd,
    input  logic             yng_we,
    input  logic [TAG_W-1:0] yng_tag,
    output logic [1:0]       take,
    output logic             iss0_vld,
    output logic [TAG_W-1:0] iss0_tag,
    output logic             iss1_vld,
    output logic [TAG_W-1:0] iss1_tag,
    output logic             mul_go,
    output logic             mem_go,
    output logic             mem_on_p1
);
    localparam int NSRC = 2;

    logic                       dep, go_old, go_yng, mul_att, mem_att, mem_p1;
    logic [NSRC-1:0][REG_W-1:0] yng_src;
    logic                       unused_old_src;

    // gather younger sources; older sources only matter to later stages
    always_comb begin
        yng_src        = {yng_rs2, yng_rs1};
        unused_old_src = ^{old_rs1, old_rs2};
    end

    di_dep_check #(.REG_W(REG_W), .NSRC(NSRC)) u_dep (
        .old_we (old_we),
        .old_rd (old_rd),
        .yng_src(yng_src),
        .yng_we (yng_we),
        .yng_rd (yng_rd),
        .dep    (dep)
    );

    di_pair_rules u_rules (
        .clk    (clk),
        .rst_n  (rst_n),
        .stall  (stall),
        .old_vld(old_vld),
        .old_cls(old_cls),
        .yng_vld(yng_vld),
        .yng_cls(yng_cls),
        .dep    (dep),
        .go_old (go_old),
        .go_yng (go_yng),
        .mul_att(mul_att),
        .mem_att(mem_att),
        .mem_p1 (mem_p1)
    );

    // consumed count back to decode, same cycle
    always_comb begin
        take = {1'b0, go_old} + {1'b0, go_yng};
    end

    di_issue_reg #(.TAG_W(TAG_W)) u_iss (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_old   (go_old),
        .go_yng   (go_yng),
        .old_tag  (old_tag),
        .yng_tag  (yng_tag),
        .mul_att  (mul_att),
        .mem_att  (mem_att),
        .mem_p1   (mem_p1),
        .iss0_vld (iss0_vld),
        .iss0_tag (iss0_tag),
        .iss1_vld (iss1_vld),
        .iss1_tag (iss1_tag),
        .mul_go   (mul_go),
        .mem_go   (mem_go),
        .mem_on_p1(mem_on_p1)
    );

    AST_TAKE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        take != 2'd3); // R3
    AST_NO_TAKE_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        !old_vld |-> (take == 2'd0)); // R2
    AST_RAW_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (old_we && (yng_rs1 == old_rd || yng_rs2 == old_rd)) |-> (take != 2'd2)); // R9
endmodule

// File: tb/tb_dual_issue_pair.sv
`timescale 1ns/1ps
module tb_dual_issue_pair;
    localparam int RW = 5;
    localparam int TW = 8;
    localparam logic [1:0] ALU = 2'b00, MUL = 2'b01, MEM = 2'b10;

    logic clk = 1'b0, rst_n = 1'b0, stall = 1'b0;
    logic old_vld = 1'b0, old_we = 1'b0, yng_vld = 1'b0, yng_we = 1'b0;
    logic [1:0] old_cls = 2'b00, yng_cls = 2'b00;
    logic [RW-1:0] old_rs1 = '0, old_rs2 = '0, old_rd = '0;
    logic [RW-1:0] yng_rs1 = '0, yng_rs2 = '0, yng_rd = '0;
    logic [TW-1:0] old_tag = '0, yng_tag = '0;
    logic [1:0] take;
    logic iss0_vld, iss1_vld, mul_go, mem_go, mem_on_p1;
    logic [TW-1:0] iss0_tag, iss1_tag;

    int n_run = 0, n_fail = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dual_issue_pair #(.REG_W(RW), .TAG_W(TW)) dut (
        .clk(clk), .rst_n(rst_n), .stall(stall),
        .old_vld(old_vld), .old_cls(old_cls), .old_rs1(old_rs1), .old_rs2(old_rs2),
        .old_rd(old_rd), .old_we(old_we), .old_tag(old_tag),
        .yng_vld(yng_vld), .yng_cls(yng_cls), .yng_rs1(yng_rs1), .yng_rs2(yng_rs2),
        .yng_rd(yng_rd), .yng_we(yng_we), .yng_tag(yng_tag),
        .take(take), .iss0_vld(iss0_vld), .iss0_tag(iss0_tag),
        .iss1_vld(iss1_vld), .iss1_tag(iss1_tag),
        .mul_go(mul_go), .mem_go(mem_go), .mem_on_p1(mem_on_p1)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // present a slot pair at a falling edge (registers: rs1, rs2, rd)
    task automatic put_old(input logic v, input logic [1:0] c, input int r1, input int r2,
                           input int rd, input logic we, input int tag);
        old_vld = v; old_cls = c; old_rs1 = RW'(r1); old_rs2 = RW'(r2);
        old_rd = RW'(rd); old_we = we; old_tag = TW'(tag);
    endtask
    task automatic put_yng(input logic v, input logic [1:0] c, input int r1, input int r2,
                           input int rd, input logic we, input int tag);
        yng_vld = v; yng_cls = c; yng_rs1 = RW'(r1); yng_rs2 = RW'(r2);
        yng_rd = RW'(rd); yng_we = we; yng_tag = TW'(tag);
    endtask

    // take is sampled 1 ns after the inputs, issue outputs at the next falling edge
    task automatic run_pair(input string req, input int exp_take, input int exp_p1,
                            input int exp_mul, input int exp_mem, input int exp_sel);
        #1;
        chk(req, "take", take, exp_take);
        @(negedge clk);
        chk(req, "iss0_vld", iss0_vld, exp_take != 0);
        if (exp_take != 0) chk(req, "iss0_tag", iss0_tag, old_tag);
        chk(req, "iss1_vld", iss1_vld, exp_p1);
        if (exp_p1 != 0) chk(req, "iss1_tag", iss1_tag, yng_tag);
        chk(req, "mul_go", mul_go, exp_mul);
        chk(req, "mem_go", mem_go, exp_mem);
        chk(req, "mem_on_p1", mem_on_p1, exp_sel);
    endtask

    task automatic t_reset();
        put_old(1, ALU, 1, 2, 3, 1, 8'h11);
        put_yng(1, ALU, 4, 5, 6, 1, 8'h12);
        @(negedge clk);
        chk("R1", "iss0_vld in reset", iss0_vld, 0);
        chk("R1", "iss1_vld in reset", iss1_vld, 0);
        chk("R1", "mem_go in reset", mem_go, 0);
        rst_n = 1'b1;
        put_old(0, ALU, 0, 0, 0, 0, 0);
        put_yng(0, ALU, 0, 0, 0, 0, 0);
        #1;
        chk("R1", "iss0_vld after reset", iss0_vld, 0);
        chk("R1", "mul_go after reset", mul_go, 0);
        @(negedge clk);
    endtask

    task automatic t_pair_alu();   // R3 R4 plain pair, class 11 acts as ALU
        put_old(1, ALU, 1, 2, 3, 1, 8'hA0);
        put_yng(1, 2'b11, 4, 5, 6, 1, 8'hA1);
        run_pair("R4", 2, 1, 0, 0, 0);
    endtask

    task automatic t_mul_old();
        put_old(1, MUL, 1, 2, 7, 1, 8'hB0);
        put_yng(1, ALU, 4, 5, 6, 1, 8'hB1);
        run_pair("R5", 2, 1, 1, 0, 0);
    endtask

    task automatic t_mul_yng();    // R6 then the queue shifts the multiply down
        put_old(1, ALU, 1, 2, 3, 1, 8'hC0);
        put_yng(1, MUL, 4, 5, 9, 1, 8'hC1);
        run_pair("R6", 1, 0, 0, 0, 0);
        put_old(1, MUL, 4, 5, 9, 1, 8'hC1);
        put_yng(1, ALU, 10, 11, 12, 1, 8'hC2);
        run_pair("R6", 2, 1, 1, 0, 0);
    endtask

    task automatic t_mem_slots();
        put_old(1, MEM, 1, 2, 3, 1, 8'hD0);
        put_yng(1, ALU, 4, 5, 6, 1, 8'hD1);
        run_pair("R7", 2, 1, 0, 1, 0);
        put_old(1, ALU, 1, 2, 3, 1, 8'hD2);
        put_yng(1, MEM, 4, 5, 6, 1, 8'hD3);
        run_pair("R7", 2, 1, 0, 1, 1);
    endtask

    task automatic t_mem_mem();
        put_old(1, MEM, 1, 2, 3, 1, 8'hE0);
        put_yng(1, MEM, 4, 5, 6, 1, 8'hE1);
        run_pair("R8", 1, 0, 0, 1, 0);
    endtask

    task automatic t_raw();
        put_old(1, ALU, 1, 2, 8, 1, 8'hF0);
        put_yng(1, ALU, 4, 8, 6, 1, 8'hF1);
        run_pair("R9", 1, 0, 0, 0, 0);
        put_old(1, ALU, 1, 2, 8, 1, 8'hF2);
        put_yng(1, ALU, 8, 5, 6, 0, 8'hF3);
        run_pair("R9", 1, 0, 0, 0, 0);
    endtask

    task automatic t_waw();
        put_old(1, ALU, 1, 2, 13, 1, 8'h30);
        put_yng(1, ALU, 4, 5, 13, 1, 8'h31);
        run_pair("R10", 1, 0, 0, 0, 0);
        put_old(1, ALU, 1, 2, 13, 0, 8'h32);   // older writes nothing
        put_yng(1, ALU, 13, 5, 13, 1, 8'h33);
        run_pair("R10", 2, 1, 0, 0, 0);
    endtask

    task automatic t_stall();
        stall = 1'b1;
        put_old(1, MEM, 1, 2, 3, 1, 8'h40);
        put_yng(1, ALU, 4, 5, 6, 1, 8'h41);
        run_pair("R11", 0, 0, 0, 0, 0);
        stall = 1'b0;
    endtask

    task automatic t_valids();
        put_old(0, ALU, 1, 2, 3, 1, 8'h50);
        put_yng(1, ALU, 4, 5, 6, 1, 8'h51);
        run_pair("R2", 0, 0, 0, 0, 0);
        put_old(1, MUL, 1, 2, 3, 1, 8'h52);
        put_yng(0, ALU, 4, 5, 6, 1, 8'h53);
        run_pair("R2", 1, 0, 1, 0, 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_pair_alu();
        t_mul_old();
        t_mul_yng();
        t_mem_slots();
        t_mem_mem();
        t_raw();
        t_waw();
        t_stall();
        t_valids();
        chk("R3", "take after idle", take, 1);
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        #20000;
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule